// File: doc/BRIEF.md
# Radix-2 Carry-Save Montgomery Word Processing Element

This block performs one outer-loop step of word-serial radix-2 Montgomery multiplication. The running result never leaves redundant form: it enters as a pair of vectors (a carry vector and a sum vector), one w-bit word of each per clock, least significant word first. With each word come the matching words of the multiplicand A and the odd modulus M, along with a single multiplier bit b that stays fixed for the whole pass. Two cascaded carry-save adders add b·A and then Q·M. The quotient bit Q is taken from word 0 and held for the remaining words. The pair is then shifted right by one bit, so each pass leaves the result halved, still in carry-save form and ready for the next element.

The shift drops the low bit of both vectors of every word, and those bits belong at the top of the word below. Because of this, each output word is completed one clock late, once the following word has been processed. The two dropped bits form a value of 0, 1 or 2, and this value sets the top bits of the previous output word. Carries out of the top of each adder's carry vector are held for one word and enter bit 0 of the next word. Only the final word of a pass waits an extra clock, and its top bits are zero. Chaining n passes with the bits of B, least significant first, gives a value congruent to A·B·2^-n modulo M.

Top module: `mont_pe_csa_r2`

## Requirements
- R1: While rst_n is low, and up to the first emitted word, out_valid is 0 and out_tc and out_ts are zero.
- R2: Let S be the value in of a pass, the sum of both input vectors across all words. Q equals bit 0 of S + b·A, is fixed by word 0 and is held for the rest of the pass. The emitted words sum to (S + b·A + Q·M)/2, provided M is odd and the top bit of A, M and each input vector is zero.
- R3: The carry leaving the top bit of each adder's carry vector enters bit 0 of the same vector on the next word. A word flagged first takes zero in both places, so nothing leaks between passes.
- R4: Output word j, where j is not the last word, is loaded on the clock edge that captures input word j+1, and out_valid is high for exactly the cycle after that edge. No word is emitted while the element waits for input.
- R5: The last word of a pass is emitted on the first edge after it is captured, whether or not new input is present. Bit w-1 of both its out_tc and out_ts is zero.
- R6: Idle cycles (in_valid low) between words or between passes do not alter any emitted word.
- R7: For each output word, the two bits dropped from the next word are summed to u (0 to 2). The top bit of out_tc is 1 only when u is 2, and the top bit of out_ts is 1 when u is at least 1. As a result, the emitted vectors each stay below 2^(e·w-1) and can feed the next pass directly.
- R8: Run over n passes with b taken from bit i of B in pass i, starting from zero, the final sum S satisfies S·2^n ≡ A·B (mod M) and S < 2M, given A < M.
- R9: out_first is high on emitted word 0 and out_last on the emitted last word, copying in_first and in_last of the corresponding input word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | A word is presented this cycle |
| in_first | input | 1 | Word 0 of a pass |
| in_last | input | 1 | Final word of a pass |
| in_bit | input | 1 | Multiplier bit b for this pass |
| a_word | input | WORD_W | Word of A |
| m_word | input | WORD_W | Word of the odd modulus M |
| tc_word | input | WORD_W | Word of the incoming carry vector |
| ts_word | input | WORD_W | Word of the incoming sum vector |
| out_valid | output | 1 | An output word is present |
| out_first | output | 1 | Output word is word 0 |
| out_last | output | 1 | Output word is the last word |
| out_tc | output | WORD_W | Word of the halved carry vector |
| out_ts | output | WORD_W | Word of the halved sum vector |

## Verification
Each output word becomes visible one cycle after the edge that captures the word above it. The last word becomes visible two cycles after its own capture edge. The bench records the cycle on which every input word is presented and works out, from those times, the exact cycle each output word is due. Every observed word is checked against that cycle, so an early, late or extra word is reported. The sum checks are made only when the last word of a pass appears. They compare the reassembled carry-save value with the arithmetic model, including passes with idle gaps inserted at varying positions.

// File: rtl/mont_pe_pkg.sv
// Shared types for the radix-2 carry-save Montgomery processing element.
package mont_pe_pkg;
    // Position tag that travels with a word through the element.
    typedef struct packed {
        logic first;
        logic last;
    } word_tag_t;
endpackage

// File: rtl/mont_csa.sv
// Bitwise 3:2 carry-save adder.
// carry[i] carries weight 2^(i+1); the caller aligns it.
module mont_csa #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] x,
    input  logic [WIDTH-1:0] y,
    input  logic [WIDTH-1:0] z,
    output logic [WIDTH-1:0] sum,
    output logic [WIDTH-1:0] carry
);
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        // Full-adder cell per bit position.
        assign sum[i]   = x[i] ^ y[i] ^ z[i];
        assign carry[i] = (x[i] & y[i]) | (x[i] & z[i]) | (y[i] & z[i]);
    end
endmodule

// File: rtl/mont_word_datapath.sv
// Combinational word step: adds b*A_j, picks/holds Q, adds Q*M_j, shifts by one.
// Assumes the caller holds the top carries and Q between words of one pass,
// and that M is odd so that word 0 leaves an even value.
module mont_word_datapath #(
    parameter int WORD_W = 16,
    localparam int LOW_W = WORD_W - 1
) (
    input  logic              first,
    input  logic              mult_bit,
    input  logic [WORD_W-1:0] a_w,
    input  logic [WORD_W-1:0] m_w,
    input  logic [WORD_W-1:0] tc_w,
    input  logic [WORD_W-1:0] ts_w,
    input  logic              held_cy1,
    input  logic              held_cy2,
    input  logic              held_q,
    output logic              q_now,
    output logic              cy1_out,
    output logic              cy2_out,
    output logic [LOW_W-1:0]  sh_tc,
    output logic [LOW_W-1:0]  sh_ts,
    output logic              drop_c,
    output logic              drop_s
);
    logic [WORD_W-1:0] ba, qm, s1, k1, c1s, s2, k2, c2s;

    // Partial product of the multiplier bit.
    assign ba = mult_bit ? a_w : '0;

    mont_csa #(.WIDTH(WORD_W)) u_csa_a (
        .x(tc_w), .y(ts_w), .z(ba), .sum(s1), .carry(k1)
    );

    // Align the first carry vector; word 0 admits no carry from below.
    assign c1s = {k1[WORD_W-2:0], first ? 1'b0 : held_cy1};

    // Quotient bit: parity of word 0 after the first addition.
    assign q_now = first ? s1[0] : held_q;
    assign qm    = q_now ? m_w : '0;

    mont_csa #(.WIDTH(WORD_W)) u_csa_m (
        .x(s1), .y(c1s), .z(qm), .sum(s2), .carry(k2)
    );

    // Align the second carry vector in the same way.
    assign c2s = {k2[WORD_W-2:0], first ? 1'b0 : held_cy2};

    // Right shift by one; the dropped bits belong to the word below.
    assign sh_ts   = s2[WORD_W-1:1];
    assign sh_tc   = c2s[WORD_W-1:1];
    assign drop_s  = s2[0];
    assign drop_c  = c2s[0];
    assign cy1_out = k1[WORD_W-1];
    assign cy2_out = k2[WORD_W-1];
endmodule

// File: rtl/mont_top_resolve.sv
// Holds each shifted word until the next word supplies its top bits,
// then registers it onto the outputs. The last word of a pass is flushed
// on the next edge with zero top bits.
module mont_top_resolve #(
    parameter int WORD_W = 16,
    localparam int LOW_W = WORD_W - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  mont_pe_pkg::word_tag_t in_tag,
    input  logic [LOW_W-1:0]  sh_tc,
    input  logic [LOW_W-1:0]  sh_ts,
    input  logic              drop_c,
    input  logic              drop_s,
    output logic              out_valid,
    output mont_pe_pkg::word_tag_t out_tag,
    output logic [WORD_W-1:0] out_tc,
    output logic [WORD_W-1:0] out_ts
);
    import mont_pe_pkg::*;

    logic [LOW_W-1:0] pend_tc, pend_ts;
    logic             pend_v;
    word_tag_t        pend_tag;
    logic             emit, u_hi, u_any, top_tc, top_ts;

    // Two dropped bits give u in {0,1,2}; spread it across both top bits.
    assign u_hi  = drop_s & drop_c;
    assign u_any = drop_s | drop_c;
    assign emit  = pend_v && (pend_tag.last || in_valid);
    assign top_tc = pend_tag.last ? 1'b0 : u_hi;
    assign top_ts = pend_tag.last ? 1'b0 : u_any;

    // Pending word register: loads every captured word, drains after a flush.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_v   <= 1'b0;
            pend_tag <= '0;
            pend_tc  <= '0;
            pend_ts  <= '0;
        end else if (in_valid) begin
            pend_v   <= 1'b1;
            pend_tag <= in_tag;
            pend_tc  <= sh_tc;
            pend_ts  <= sh_ts;
        end else if (emit) begin
            pend_v   <= 1'b0;
        end
    end

    // Output register: completes the pending word with its resolved top bits.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_tc    <= '0;
            out_ts    <= '0;
        end else begin
            out_valid <= emit;
            if (emit) begin
                out_tag <= pend_tag;
                out_tc  <= {top_tc, pend_tc};
                out_ts  <= {top_ts, pend_ts};
            end
        end
    end
endmodule

// File: rtl/mont_pe_csa_r2.sv
// Radix-2 carry-save Montgomery processing element (one outer step per pass).
// Assumes: words arrive least significant first, in_first on word 0 and
// in_last on the final word; M odd; top bit of A, M, TC and TS vectors zero.
module mont_pe_csa_r2 #(
    parameter int WORD_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              in_bit,
    input  logic [WORD_W-1:0] a_word,
    input  logic [WORD_W-1:0] m_word,
    input  logic [WORD_W-1:0] tc_word,
    input  logic [WORD_W-1:0] ts_word,
    output logic              out_valid,
    output logic              out_first,
    output logic              out_last,
    output logic [WORD_W-1:0] out_tc,
    output logic [WORD_W-1:0] out_ts
);
    import mont_pe_pkg::*;
    localparam int LOW_W = WORD_W - 1;

    logic             held_cy1, held_cy2, held_q;
    logic             w_q, w_cy1, w_cy2, w_drop_c, w_drop_s;
    logic [LOW_W-1:0] w_sh_tc, w_sh_ts;
    word_tag_t        in_tag, o_tag;

    assign in_tag = '{first: in_first, last: in_last};

    mont_word_datapath #(.WORD_W(WORD_W)) u_dp (
        .first   (in_first),
        .mult_bit(in_bit),
        .a_w     (a_word),
        .m_w     (m_word),
        .tc_w    (tc_word),
        .ts_w    (ts_word),
        .held_cy1(held_cy1),
        .held_cy2(held_cy2),
        .held_q  (held_q),
        .q_now   (w_q),
        .cy1_out (w_cy1),
        .cy2_out (w_cy2),
        .sh_tc   (w_sh_tc),
        .sh_ts   (w_sh_ts),
        .drop_c  (w_drop_c),
        .drop_s  (w_drop_s)
    );

    // Word-to-word state: top carries of both adders and the pass quotient.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_cy1 <= 1'b0;
            held_cy2 <= 1'b0;
            held_q   <= 1'b0;
        end else if (in_valid) begin
            held_cy1 <= w_cy1;
            held_cy2 <= w_cy2;
            if (in_first) held_q <= w_q;
        end
    end

    mont_top_resolve #(.WORD_W(WORD_W)) u_res (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_tag   (in_tag),
        .sh_tc    (w_sh_tc),
        .sh_ts    (w_sh_ts),
        .drop_c   (w_drop_c),
        .drop_s   (w_drop_s),
        .out_valid(out_valid),
        .out_tag  (o_tag),
        .out_tc   (out_tc),
        .out_ts   (out_ts)
    );

    assign out_first = o_tag.first;
    assign out_last  = o_tag.last;
endmodule

// File: rtl/mont_pe_csa_r2_chk.sv
// Temporal properties of the processing element, bound to the top module.
module mont_pe_csa_r2_chk #(
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              in_first,
    input logic              in_last,
    input logic [WORD_W-1:0] m_word,
    input logic              w_drop_s,
    input logic              out_valid,
    input logic              out_last,
    input logic [WORD_W-1:0] out_tc,
    input logic [WORD_W-1:0] out_ts
);
    // R2: with M odd, the quotient makes word 0 even, so nothing drops below it.
    p_word0_even_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_first && m_word[0] |-> !w_drop_s);

    // R5: the final word of a pass leaves with both top bits clear.
    p_last_top_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_last |-> !out_tc[WORD_W-1] && !out_ts[WORD_W-1]);

    // R5: a captured last word (of a multi-word pass) appears two cycles later.
    p_last_flush_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && in_last && !in_first, 2) |-> out_valid && out_last);

    // R4: non-final words are only emitted by the arrival of a following word.
    p_emit_by_input_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_last |-> $past(in_valid));
endmodule

bind mont_pe_csa_r2 mont_pe_csa_r2_chk #(.WORD_W(WORD_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_first (in_first),
    .in_last  (in_last),
    .m_word   (m_word),
    .w_drop_s (w_drop_s),
    .out_valid(out_valid),
    .out_last (out_last),
    .out_tc   (out_tc),
    .out_ts   (out_ts)
);

// File: tb/mont_pe_csa_r2_tb.sv
// Bench: w=4, three words per vector (12-bit vectors), ten passes per product.
module mont_pe_csa_r2_tb;
    localparam int W  = 4;
    localparam int E  = 3;
    localparam int NB = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0, in_bit = 1'b0;
    logic [W-1:0] a_word = '0, m_word = '0, tc_word = '0, ts_word = '0;
    logic out_valid, out_first, out_last;
    logic [W-1:0] out_tc, out_ts;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    int in_cyc [E];
    int oidx = 0;
    longint osum = 0;
    bit done = 1'b0;

    longint q_exp[$];
    bit     q_fin[$];
    longint q_a[$], q_b[$], q_m[$];

    mont_pe_csa_r2 #(.WORD_W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_first(in_first),
        .in_last(in_last), .in_bit(in_bit), .a_word(a_word), .m_word(m_word),
        .tc_word(tc_word), .ts_word(ts_word), .out_valid(out_valid),
        .out_first(out_first), .out_last(out_last), .out_tc(out_tc),
        .out_ts(out_ts)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
        end
    endtask

    task automatic drive_word(input int j, input bit b, input longint a, input longint m,
                              input longint tc, input longint ts);
        @(negedge clk);
        in_valid = 1'b1;
        in_first = (j == 0);
        in_last  = (j == E-1);
        in_bit   = b;
        a_word   = W'(a >> (W*j));
        m_word   = W'(m >> (W*j));
        tc_word  = W'(tc >> (W*j));
        ts_word  = W'(ts >> (W*j));
        in_cyc[j] = cyc;
    endtask

    task automatic idle();
        @(negedge clk);
        in_valid = 1'b0;
        in_first = 1'b0;
        in_last  = 1'b0;
    endtask

    // Output monitor: timing (R4, R5), flags (R9), tops (R7), sums (R2, R8).
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            int ecyc;
            ecyc = (oidx < E-1) ? in_cyc[oidx+1] + 1 : in_cyc[E-1] + 2;
            check(cyc == ecyc, (oidx < E-1) ? "R4 word timing" : "R5 last-word timing", cyc, ecyc);
            check(out_first == (oidx == 0), "R9 first flag", out_first, oidx == 0);
            check(out_last == (oidx == E-1), "R9 last flag", out_last, oidx == E-1);
            osum += (longint'(out_tc) + longint'(out_ts)) << (W*oidx);
            if (oidx == E-1) begin
                check(out_tc[W-1] == 1'b0 && out_ts[W-1] == 1'b0, "R5 R7 top bits of last word",
                      {out_tc[W-1], out_ts[W-1]}, 0);
                if (q_exp.size() == 0) begin
                    check(1'b0, "R4 unexpected pass output", osum, -1);
                end else begin
                    longint e, a, b, m;
                    bit f;
                    e = q_exp.pop_front(); f = q_fin.pop_front();
                    a = q_a.pop_front(); b = q_b.pop_front(); m = q_m.pop_front();
                    check(osum == e, "R2 R3 R6 R7 pass sum", osum, e);
                    if (f) begin
                        check(((osum << NB) % m) == ((a * b) % m), "R8 congruence",
                              (osum << NB) % m, (a * b) % m);
                        check(osum < 2*m, "R8 bound", osum, 2*m);
                    end
                end
                oidx = 0;
                osum = 0;
            end else begin
                oidx++;
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        // R1: quiet outputs under reset and right after it.
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R1 valid in reset", out_valid, 0);
        check(out_tc == '0 && out_ts == '0, "R1 data in reset", {out_tc, out_ts}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid == 1'b0, "R1 valid after reset", out_valid, 0);

        for (int t = 0; t < 48; t++) begin
            longint m, a, bb, s;
            m  = longint'((1023 - 21*t) | 1);
            a  = (longint'(t) * 379 + 7) % m;
            bb = (longint'(t) * 613 + 5) & 1023;
            if (t == 0) begin a = m - 1; bb = 1023; end
            if (t == 1) begin a = 0; end
            s = 0;
            for (int it = 0; it < NB; it++) begin
                bit b, q;
                longint sn, mask, tcf, tsf;
                b  = bb[it];
                q  = (s + (b ? a : 0)) & 1;
                sn = (s + (b ? a : 0) + (q ? m : 0)) / 2;
                q_exp.push_back(sn); q_fin.push_back(it == NB-1);
                q_a.push_back(a); q_b.push_back(bb); q_m.push_back(m);
                case ((t + it) % 4)
                    0: mask = 'h555;
                    1: mask = 'h3F0;
                    2: mask = 0;
                    default: mask = 'h7FF;
                endcase
                tcf = s & mask;
                tsf = s - tcf;
                for (int j = 0; j < E; j++) begin
                    drive_word(j, b, a, m, tcf, tsf);
                    if (j < E-1 && ((t*7 + it*3 + j) % 5 == 0)) idle();
                    if (j < E-1 && ((t + it + j) % 11 == 0)) idle();
                end
                if ((t + it) % 3 == 0) idle();
                s = sn;
            end
        end
        repeat (6) idle();
        check(q_exp.size() == 0, "R4 all passes emitted", q_exp.size(), 0);
        check(oidx == 0, "R9 no partial pass left", oidx, 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule